// File: doc/BRIEF.md
# UTOPIA Level 2 PHY-Side Receive Responder

This block is the cell-receiving half of an 8-bit UTOPIA port on a device that plays the PHY role. An ATM-layer master drives a 5-bit address bus, an active-low enable, a byte lane and a start-of-cell flag. The block answers the master's polls on a single cell-available line. It accepts cell bytes while it is selected and the enable is low, and passes each byte and its start-of-cell marker to a downstream FIFO. That FIFO reports back only a full flag.

A configuration input chooses Level 1 or Level 2 operation. In Level 2 the block compares the address bus with a programmable match address. It drives cell-available only in the cycle after its own address is polled, and releases the line at all other times, so several PHYs can share it. The shared line is modelled as a drive-enable plus a data bit. In Level 1 the address is ignored and the line is always driven. A no-inhibit bit decides whether a full FIFO pulls cell-available low. A sticky overrun flag records any byte accepted while the FIFO was full.

A three-state controller tracks reception. ST_IDLE means not selected. ST_SEL means selected and waiting for a start-of-cell. ST_CELL means inside a 53-byte cell. Its transitions are:

- sel_hit: ST_IDLE to ST_SEL, when enable is high and the address hits.
- sel_miss: ST_SEL to ST_IDLE, when enable is high and the address misses.
- cell_start: ST_SEL to ST_CELL, when a byte carrying start-of-cell is accepted.
- cell_restart: stays in ST_CELL, when start-of-cell arrives mid-cell and the byte count restarts.
- cell_done: ST_CELL to ST_SEL, after the 53rd byte.

Top module: `utopia_rx_responder`

## Requirements
- R1: While reset is held low, utp_clav_oe, fifo_wr, fifo_soc and ovr_flag are all 0.
- R2: With cfg_level2=1, if utp_addr equals cfg_match_addr at a clock edge, utp_clav_oe is 1 in the following cycle.
- R3: With cfg_level2=1, if utp_addr differs from cfg_match_addr at a clock edge, utp_clav_oe is 0 in the following cycle (line released).
- R4: With cfg_level2=0, the address bus is ignored. utp_clav_oe is 1 in every cycle after the first edge following reset, and a selection needs only one cycle with utp_enb_n high.
- R5: Address 31 (all ones) is the null address. It never produces a hit, even when cfg_match_addr is 31.
- R6: With cfg_no_inhibit=0, the driven value of utp_clav in a cycle is the inverse of fifo_full sampled at the previous edge (1 = room for a cell).
- R7: With cfg_no_inhibit=1, the driven value of utp_clav is 1 whatever fifo_full is.
- R8: A byte is written to the FIFO (fifo_wr=1, fifo_data=the byte) in the cycle after an edge at which utp_enb_n was low while the block was selected.
- R9: Outside a cell, a byte whose utp_soc is 0 is dropped. A byte with utp_soc=1 starts a cell, and fifo_soc=1 accompanies its write. A start-of-cell inside a cell restarts the byte count.
- R10: A cell is 53 bytes. After the 53rd byte, further bytes are dropped until a new start-of-cell.
- R11: ovr_flag is set when a byte is accepted while fifo_full=1. It stays set until a cycle with cfg_ovr_clear=1, and a new overrun in that same cycle wins over the clear.
- R12: Selection is decided at edges where utp_enb_n is high and the block is not inside a cell. A hit selects the block. A miss, including the null address, deselects it, and bytes sent while deselected are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_level2 | input | 1 | 1 = Level 2 addressed mode, 0 = Level 1 |
| cfg_match_addr | input | 5 | Own PHY address in Level 2 |
| cfg_no_inhibit | input | 1 | 1 = keep cell-available high even when FIFO is full |
| cfg_ovr_clear | input | 1 | Clears the overrun flag |
| utp_addr | input | 5 | Address driven by the ATM-layer master |
| utp_enb_n | input | 1 | Active-low transfer enable from the master |
| utp_data | input | 8 | Cell byte lane |
| utp_soc | input | 1 | Start-of-cell marker |
| utp_clav | output | 1 | Cell-available value, meaningful when utp_clav_oe is 1 |
| utp_clav_oe | output | 1 | Drive enable of the shared cell-available line |
| fifo_full | input | 1 | Downstream FIFO full flag |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | Byte written to the FIFO |
| fifo_soc | output | 1 | Start-of-cell marker of the written byte |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The assertions assume the master keeps to the bus discipline. A selection is only meaningful when the enable is high, and the configuration inputs change only between transfers. The assertions do not need fifo_full to behave like a real FIFO. The stimulus changes configuration only during idle or poll cycles, sweeps every pair of match and polled address together with every combination of full and no-inhibit, and sends bytes only after an explicit selection cycle. It also covers deselected and mid-cell cases on purpose.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_CELL = 2'd2
    } rx_state_e;
endpackage

// File: rtl/utopia_rx_addr_match.sv
module utopia_rx_addr_match #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] match_addr,
    input  logic              level2,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

    always_comb begin
        if (level2) begin
            hit = (addr == match_addr) && (match_addr != NULL_ADDR);
        end else begin
            hit = 1'b1;
        end
    end
endmodule

// File: rtl/utopia_rx_clav_drv.sv
module utopia_rx_clav_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic no_inhibit,
    input  logic fifo_full,
    output logic clav,
    output logic clav_oe
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clav_oe <= 1'b0;
            clav    <= 1'b0;
        end else begin
            clav_oe <= hit;
            clav    <= no_inhibit | ~fifo_full;
        end
    end
endmodule

// File: rtl/utopia_rx_cell_fsm.sv
module utopia_rx_cell_fsm
    import utopia_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              enb_n,
    input  logic [DATA_W-1:0] data,
    input  logic              soc,
    input  logic              fifo_full,
    input  logic              ovr_clear,
    output logic              wr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_soc,
    output logic              ovr
);
    localparam int                CNT_W = $clog2(CELL_BYTES);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(CELL_BYTES - 1);
    localparam logic [CNT_W-1:0]  ONE   = CNT_W'(1);

    rx_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             accept;

    always_comb begin
        accept = 1'b0;
        unique case (state)
            ST_IDLE: accept = 1'b0;
            ST_SEL:  accept = ~enb_n & soc;
            ST_CELL: accept = ~enb_n;
            default: accept = 1'b0;
        endcase
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (enb_n && hit) begin
                    state_nx = ST_SEL;            // sel_hit
                end
            end
            ST_SEL: begin
                if (enb_n && !hit) begin
                    state_nx = ST_IDLE;           // sel_miss
                end else if (accept) begin
                    state_nx = ST_CELL;           // cell_start
                    cnt_nx   = ONE;
                end
            end
            ST_CELL: begin
                if (accept) begin
                    if (soc) begin
                        cnt_nx = ONE;             // cell_restart
                    end else if (cnt == LAST) begin
                        state_nx = ST_SEL;        // cell_done
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + ONE;
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr      <= 1'b0;
            wr_data <= '0;
            wr_soc  <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            wr      <= accept;
            wr_data <= accept ? data : wr_data;
            wr_soc  <= accept & soc;
            ovr     <= (ovr & ~ovr_clear) | (accept & fifo_full);
        end
    end
endmodule

// File: rtl/utopia_rx_responder.sv
module utopia_rx_responder #(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_level2,
    input  logic [ADDR_W-1:0] cfg_match_addr,
    input  logic              cfg_no_inhibit,
    input  logic              cfg_ovr_clear,
    input  logic [ADDR_W-1:0] utp_addr,
    input  logic              utp_enb_n,
    input  logic [DATA_W-1:0] utp_data,
    input  logic              utp_soc,
    output logic              utp_clav,
    output logic              utp_clav_oe,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_soc,
    output logic              ovr_flag
);
    logic hit;

    utopia_rx_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .addr       (utp_addr),
        .match_addr (cfg_match_addr),
        .level2     (cfg_level2),
        .hit        (hit)
    );

    utopia_rx_clav_drv u_clav (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .no_inhibit (cfg_no_inhibit),
        .fifo_full  (fifo_full),
        .clav       (utp_clav),
        .clav_oe    (utp_clav_oe)
    );

    utopia_rx_cell_fsm #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .enb_n     (utp_enb_n),
        .data      (utp_data),
        .soc       (utp_soc),
        .fifo_full (fifo_full),
        .ovr_clear (cfg_ovr_clear),
        .wr        (fifo_wr),
        .wr_data   (fifo_data),
        .wr_soc    (fifo_soc),
        .ovr       (ovr_flag)
    );
endmodule

// File: rtl/utopia_rx_chk.sv
module utopia_rx_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_level2,
    input logic [ADDR_W-1:0] cfg_match_addr,
    input logic              cfg_no_inhibit,
    input logic              cfg_ovr_clear,
    input logic [ADDR_W-1:0] utp_addr,
    input logic              utp_enb_n,
    input logic              utp_clav,
    input logic              utp_clav_oe,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic              fifo_soc,
    input logic              ovr_flag
);
    localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!utp_clav_oe && !fifo_wr && !fifo_soc && !ovr_flag || $past(rst_n)); // R1
        end
    end

    AST_POLL_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level2 && utp_addr == cfg_match_addr && cfg_match_addr != NULL_ADDR) |=> utp_clav_oe); // R2
    AST_MISS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level2 && utp_addr != cfg_match_addr) |=> !utp_clav_oe); // R3
    AST_L1_ALWAYS_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_level2 |=> utp_clav_oe); // R4
    AST_NULL_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_level2 && utp_addr == NULL_ADDR) |=> !utp_clav_oe); // R5
    AST_FULL_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_no_inhibit && fifo_full) |=> !(utp_clav_oe && utp_clav)); // R6
    AST_NO_INHIBIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_no_inhibit |=> (!utp_clav_oe || utp_clav)); // R7
    AST_WR_AFTER_ENB: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(!utp_enb_n)); // R8
    AST_SOC_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_soc |-> fifo_wr); // R9
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && $past(fifo_full)) |-> ovr_flag); // R11
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !cfg_ovr_clear) |=> ovr_flag); // R11
endmodule

bind utopia_rx_responder utopia_rx_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_level2     (cfg_level2),
    .cfg_match_addr (cfg_match_addr),
    .cfg_no_inhibit (cfg_no_inhibit),
    .cfg_ovr_clear  (cfg_ovr_clear),
    .utp_addr       (utp_addr),
    .utp_enb_n      (utp_enb_n),
    .utp_clav       (utp_clav),
    .utp_clav_oe    (utp_clav_oe),
    .fifo_full      (fifo_full),
    .fifo_wr        (fifo_wr),
    .fifo_soc       (fifo_soc),
    .ovr_flag       (ovr_flag)
);

// File: tb/tb_utopia_rx_responder.sv
`timescale 1ns/1ps
module tb_utopia_rx_responder;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int CELL_BYTES = 53;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_level2;
    logic [ADDR_W-1:0] cfg_match_addr;
    logic              cfg_no_inhibit;
    logic              cfg_ovr_clear;
    logic [ADDR_W-1:0] utp_addr;
    logic              utp_enb_n;
    logic [DATA_W-1:0] utp_data;
    logic              utp_soc;
    logic              utp_clav;
    logic              utp_clav_oe;
    logic              fifo_full;
    logic              fifo_wr;
    logic [DATA_W-1:0] fifo_data;
    logic              fifo_soc;
    logic              ovr_flag;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    utopia_rx_responder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_level2(cfg_level2), .cfg_match_addr(cfg_match_addr),
        .cfg_no_inhibit(cfg_no_inhibit), .cfg_ovr_clear(cfg_ovr_clear), .utp_addr(utp_addr),
        .utp_enb_n(utp_enb_n), .utp_data(utp_data), .utp_soc(utp_soc), .utp_clav(utp_clav),
        .utp_clav_oe(utp_clav_oe), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .fifo_soc(fifo_soc), .ovr_flag(ovr_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic poll(input logic [ADDR_W-1:0] a);
        utp_enb_n = 1'b1;
        utp_soc   = 1'b0;
        utp_addr  = a;
        tick();
    endtask

    task automatic put_byte(input logic [DATA_W-1:0] d, input logic s);
        utp_enb_n = 1'b0;
        utp_data  = d;
        utp_soc   = s;
        tick();
    endtask

    task automatic do_reset(input logic lvl2);
        rst_n          = 1'b0;
        cfg_level2     = lvl2;
        cfg_match_addr = 5'd5;
        cfg_no_inhibit = 1'b0;
        cfg_ovr_clear  = 1'b0;
        utp_addr       = 5'd31;
        utp_enb_n      = 1'b1;
        utp_data       = '0;
        utp_soc        = 1'b0;
        fifo_full      = 1'b0;
        tick();
        tick();
        check("R1 clav_oe in reset", int'(utp_clav_oe), 0);
        check("R1 fifo_wr in reset", int'(fifo_wr), 0);
        check("R1 fifo_soc in reset", int'(fifo_soc), 0);
        check("R1 ovr_flag in reset", int'(ovr_flag), 0);
        rst_n = 1'b1;
    endtask

    // Sends a full cell starting with start-of-cell and checks every write.
    task automatic send_cell(input int seed, input string tag);
        for (int i = 0; i < CELL_BYTES; i++) begin
            put_byte(DATA_W'((i * 7 + seed) & 255), i == 0);
            check({tag, " write strobe"}, int'(fifo_wr), 1);
            check({tag, " write data"}, int'(fifo_data), (i * 7 + seed) & 255);
            check({tag, " R9 soc marker"}, int'(fifo_soc), (i == 0) ? 1 : 0);
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b1);

        // Level 2 poll sweep: every match/address pair, full and no-inhibit
        for (int m = 0; m < 32; m++) begin
            for (int a = 0; a < 32; a++) begin
                for (int k = 0; k < 4; k++) begin
                    cfg_match_addr = ADDR_W'(m);
                    fifo_full      = k[0];
                    cfg_no_inhibit = k[1];
                    poll(ADDR_W'(a));
                    if (m == 31) begin
                        check("R5 null never hits", int'(utp_clav_oe), 0);
                    end else if (a == m) begin
                        check("R2 drive after own poll", int'(utp_clav_oe), 1);
                        if (k[1]) check("R7 clav forced high", int'(utp_clav), 1);
                        else      check("R6 clav follows full", int'(utp_clav), k[0] ? 0 : 1);
                    end else begin
                        check("R3 released on other poll", int'(utp_clav_oe), 0);
                    end
                end
            end
        end

        // Level 1 sweep: address ignored, line always driven
        cfg_level2     = 1'b0;
        cfg_match_addr = 5'd0;
        for (int a = 0; a < 32; a++) begin
            for (int k = 0; k < 4; k++) begin
                fifo_full      = k[0];
                cfg_no_inhibit = k[1];
                poll(ADDR_W'(a));
                check("R4 level1 always driven", int'(utp_clav_oe), 1);
                if (k[1]) check("R7 level1 clav high", int'(utp_clav), 1);
                else      check("R6 level1 clav", int'(utp_clav), k[0] ? 0 : 1);
            end
        end
        fifo_full      = 1'b0;
        cfg_no_inhibit = 1'b0;

        // Level 2 cell reception
        do_reset(1'b1);
        poll(5'd5);
        send_cell(3, "R8 R10 cell");
        put_byte(8'hAA, 1'b0);
        check("R10 byte after 53 dropped", int'(fifo_wr), 0);
        put_byte(8'h11, 1'b0);
        check("R9 no soc outside cell dropped", int'(fifo_wr), 0);
        put_byte(8'h22, 1'b1);
        check("R9 soc starts cell", int'(fifo_wr), 1);
        check("R9 soc marker on start", int'(fifo_soc), 1);
        for (int i = 0; i < 10; i++) put_byte(8'h30, 1'b0);
        // restart mid-cell: 53 bytes from the new start-of-cell
        send_cell(9, "R9 restart");
        put_byte(8'h55, 1'b0);
        check("R9 restart count ends at 53", int'(fifo_wr), 0);

        // Deselect and reselect
        poll(5'd7);
        put_byte(8'h66, 1'b1);
        check("R12 deselected byte not written", int'(fifo_wr), 0);
        put_byte(8'h67, 1'b0);
        check("R12 deselected byte not written", int'(fifo_wr), 0);
        poll(5'd31);
        put_byte(8'h68, 1'b1);
        check("R12 null poll keeps deselected", int'(fifo_wr), 0);
        poll(5'd5);
        put_byte(8'h69, 1'b1);
        check("R12 reselected byte written", int'(fifo_wr), 1);
        check("R8 reselected data", int'(fifo_data), 8'h69);

        // Overrun flag
        fifo_full = 1'b1;
        put_byte(8'h70, 1'b0);
        check("R11 overrun set", int'(ovr_flag), 1);
        fifo_full = 1'b0;
        poll(5'd5);
        check("R11 overrun sticky", int'(ovr_flag), 1);
        cfg_ovr_clear = 1'b1;
        poll(5'd5);
        cfg_ovr_clear = 1'b0;
        check("R11 overrun cleared", int'(ovr_flag), 0);
        fifo_full     = 1'b1;
        cfg_ovr_clear = 1'b1;
        put_byte(8'h71, 1'b0);
        check("R11 set wins over clear", int'(ovr_flag), 1);
        fifo_full = 1'b0;
        poll(5'd5);
        cfg_ovr_clear = 1'b0;
        check("R11 cleared after set", int'(ovr_flag), 0);

        // Level 1 cell reception, address ignored
        do_reset(1'b0);
        poll(5'd17);
        send_cell(40, "R4 level1 cell");
        put_byte(8'h01, 1'b0);
        check("R10 level1 byte after cell dropped", int'(fifo_wr), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule